// File: doc/BRIEF.md
# Round-robin execution unit selector

This block manages one pool of identical execution units. The pool is either a plain resource with several units or a group built from member units. When an operation is dispatched, the block chooses which unit it uses. Rotation goes from the highest-numbered remaining unit down to the lowest. A caller can also pin an operation to a given unit. The block keeps a mask of free units, which shrinks when a unit is granted and grows back when the caller returns the unit. A reservation flag can block the whole pool. A readiness output compares the number of free units with a requested count.

The member set comes from parameters, not from software. A group passes an identity mask one bit wider than the pool; its top set bit names the group itself and is discarded. A plain resource passes a unit count, and its members are the low bits of the pool. A unit that is pinned out of turn, after the rotation has already passed it, is remembered. That unit is skipped once in the next round, so it is not favoured twice.

Top module: `rrsel_pool`

## Requirements
- R1: The member mask is the group identity mask (bit W must be its highest set bit) with that top bit removed when IS_GROUP is 1; otherwise it is the low UNIT_COUNT bits set.
- R2: After reset the rotation mask and ready mask equal the member mask, the removed set is zero and the pool is not reserved.
- R3: An unforced select grants the highest set bit of the rotation mask as a one-hot on the same cycle. It clears that bit on the next edge. With no select, the grant is zero.
- R4: When a select leaves the rotation mask at zero, the rotation mask reloads to the member mask minus the removed set, including any bit added that cycle. The removed set then becomes zero.
- R5: A forced select grants the forced one-hot unit. If that unit's bit is set in the rotation mask, the bit is cleared. Otherwise the unit is added to the removed set and the rotation mask is unchanged.
- R6: A granted unit that is ready leaves the ready mask on the next edge. Granting a unit that is not ready raises err_use on that cycle and leaves the ready mask unchanged.
- R7: Releasing a unit that is not ready sets its ready bit on the next edge. Releasing a unit that is already ready raises err_release on that cycle and changes nothing.
- R8: pool_ready is high when the pool is not reserved and the number of ready bits is at least need_count. reserve_set sets the reserved flag and takes priority over reserve_clr, which clears it.
- R9: err_empty is high exactly when an unforced select meets an all-zero rotation mask. In that case the grant is zero and the rotation mask reloads. Starting from reset this cannot occur, because the last unit taken in a round is never in the removed set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_req | input | 1 | Request a unit this cycle |
| force_en | input | 1 | Use force_unit instead of the rotation |
| force_unit | input | W | One-hot unit pinned by the caller |
| release_en | input | 1 | Return a unit to the ready mask |
| release_unit | input | W | One-hot unit being returned |
| reserve_set | input | 1 | Reserve the whole pool |
| reserve_clr | input | 1 | Clear the reservation |
| need_count | input | $clog2(W+1) | Units needed for pool_ready |
| grant_unit | output | W | One-hot chosen unit, zero when idle |
| pool_ready | output | 1 | Not reserved and enough units free |
| ready_mask | output | W | Free units |
| rot_mask | output | W | Units left in the current round |
| removed_mask | output | W | Units to skip at the next reload |
| err_use | output | 1 | Granted unit was not ready |
| err_release | output | 1 | Released unit was already ready |
| err_empty | output | 1 | Unforced select on an empty rotation |

## Verification
The bench builds two four-unit copies. The first is a plain resource with three units, so bit 3 is never a member. The second is a group whose identity mask 5'b10101 leaves the members at units 0 and 2. With these two, both ways of forming the member set can be checked, and a gap inside the pool appears in the rotation. The group copy also makes it easy to force a unit the rotation has already passed. Both copies take the same stimulus, so forcing or releasing a non-member exercises the error flags and shows that the removed set does not leak past the member mask.

// File: rtl/rrsel_pkg.sv
package rrsel_pkg;
   localparam int unsigned MAX_UNITS = 16;
   localparam int unsigned VEC_W     = MAX_UNITS + 1;

   // isolate the highest set bit of a vector
   function automatic logic [VEC_W-1:0] top_bit17(input logic [VEC_W-1:0] v);
      logic [VEC_W-1:0] r;
      r = '0;
      for (int i = 0; i < VEC_W; i++)
         if (v[i]) r = VEC_W'(1) << i;
      return r;
   endfunction

   function automatic int unsigned ones17(input logic [VEC_W-1:0] v);
      int unsigned n;
      n = 0;
      for (int i = 0; i < VEC_W; i++)
         n += 32'(v[i]);
      return n;
   endfunction
endpackage

// File: rtl/rrsel_rotor.sv
module rrsel_rotor
   import rrsel_pkg::*;
#(
   parameter int unsigned    W      = 4,
   parameter logic [W-1:0]   MEMBER = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sel_req,
   input  logic         force_en,
   input  logic [W-1:0] force_unit,
   output logic [W-1:0] grant,
   output logic         empty_err,
   output logic [W-1:0] rot_q,
   output logic [W-1:0] removed_q
);
   logic [VEC_W-1:0] top_full;
   logic [W-1:0]     natural_pick;
   logic [W-1:0]     rot_after, rem_after;

   always_comb begin
      top_full     = top_bit17(VEC_W'(rot_q));
      natural_pick = top_full[W-1:0];
      grant        = '0;
      if (sel_req) grant = force_en ? force_unit : natural_pick;
      empty_err    = sel_req && !force_en && (rot_q == '0);
   end

   always_comb begin
      rot_after = rot_q;
      rem_after = removed_q;
      if (sel_req) begin
         if (force_en && ((rot_q & force_unit) == '0))
            rem_after = removed_q | force_unit;
         else
            rot_after = rot_q & ~grant;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rot_q     <= MEMBER;
         removed_q <= '0;
      end else if (sel_req && (rot_after == '0)) begin
         rot_q     <= MEMBER & ~rem_after;
         removed_q <= '0;
      end else begin
         rot_q     <= rot_after;
         removed_q <= rem_after;
      end
   end

   p_rot_in_member_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_q & ~MEMBER) == '0);
   p_natural_is_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_req && !force_en && rot_q != '0) |-> ($onehot(grant) && ((rot_q ^ grant) < grant)));
   p_force_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_req && force_en) |-> $onehot(force_unit));
   p_empty_no_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
      empty_err |-> (grant == '0));
endmodule

// File: rtl/rrsel_ready.sv
module rrsel_ready #(
   parameter int unsigned  W      = 4,
   parameter logic [W-1:0] MEMBER = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] take_unit,
   input  logic         rel_en,
   input  logic [W-1:0] rel_unit,
   output logic [W-1:0] ready_q,
   output logic         err_take,
   output logic         err_rel
);
   logic [W-1:0] take_ok, rel_ok;

   always_comb begin
      err_take = |(take_unit & ~ready_q);
      take_ok  = err_take ? '0 : take_unit;
      err_rel  = rel_en && |(rel_unit & ready_q);
      rel_ok   = (rel_en && !err_rel) ? rel_unit : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ready_q <= MEMBER;
      else        ready_q <= (ready_q | rel_ok) & ~take_ok;
   end

   p_take_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((take_unit != '0) && !err_take) |=> ((ready_q & $past(take_unit)) == '0));
   p_bad_take_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_take && !rel_en) |=> $stable(ready_q));
   p_release_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_en && !err_rel) |=> ((ready_q & $past(rel_unit)) != '0));
endmodule

// File: rtl/rrsel_pool.sv
module rrsel_pool
   import rrsel_pkg::*;
#(
   parameter int unsigned      W          = 4,
   parameter bit               IS_GROUP   = 1'b0,
   parameter int unsigned      UNIT_COUNT = 4,
   parameter logic [VEC_W-1:0] ID_MASK    = '0,
   localparam int unsigned     NW         = $clog2(W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_req,
   input  logic          force_en,
   input  logic [W-1:0]  force_unit,
   input  logic          release_en,
   input  logic [W-1:0]  release_unit,
   input  logic          reserve_set,
   input  logic          reserve_clr,
   input  logic [NW-1:0] need_count,
   output logic [W-1:0]  grant_unit,
   output logic          pool_ready,
   output logic [W-1:0]  ready_mask,
   output logic [W-1:0]  rot_mask,
   output logic [W-1:0]  removed_mask,
   output logic          err_use,
   output logic          err_release,
   output logic          err_empty
);
   localparam logic [VEC_W-1:0] ID_STRIP   = ID_MASK ^ top_bit17(ID_MASK);
   localparam logic [VEC_W-1:0] COUNT_FILL = (VEC_W'(1) << UNIT_COUNT) - VEC_W'(1);
   localparam logic [W-1:0]     MEMBER     = IS_GROUP ? ID_STRIP[W-1:0] : COUNT_FILL[W-1:0];

   generate
      if (W < 1 || W > MAX_UNITS) begin : g_bad_width
         $error("rrsel_pool: W must be 1..16");
      end
      if (IS_GROUP) begin : g_group_check
         if (top_bit17(ID_MASK) != (VEC_W'(1) << W))
            $error("rrsel_pool: group identity must have bit W as its top bit");
         if (ones17(ID_MASK) < 2)
            $error("rrsel_pool: group needs at least one member");
      end else begin : g_plain_check
         if (UNIT_COUNT < 1 || UNIT_COUNT > W)
            $error("rrsel_pool: UNIT_COUNT must be 1..W");
      end
   endgenerate

   logic reserved_q;

   rrsel_rotor #(.W(W), .MEMBER(MEMBER)) u_rotor (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_req    (sel_req),
      .force_en   (force_en),
      .force_unit (force_unit),
      .grant      (grant_unit),
      .empty_err  (err_empty),
      .rot_q      (rot_mask),
      .removed_q  (removed_mask)
   );

   rrsel_ready #(.W(W), .MEMBER(MEMBER)) u_ready (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_unit (grant_unit),
      .rel_en    (release_en),
      .rel_unit  (release_unit),
      .ready_q   (ready_mask),
      .err_take  (err_use),
      .err_rel   (err_release)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)           reserved_q <= 1'b0;
      else if (reserve_set) reserved_q <= 1'b1;
      else if (reserve_clr) reserved_q <= 1'b0;
   end

   assign pool_ready = !reserved_q && (ones17(VEC_W'(ready_mask)) >= 32'(need_count));

   p_reserved_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reserved_q |-> !pool_ready);
   p_reserve_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reserve_set |=> !pool_ready);
endmodule

// File: tb/sim_rrsel_pool.sv
`timescale 1ns/1ps
module sim_rrsel_pool;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       sel_req, force_en, release_en, reserve_set, reserve_clr;
   logic [3:0] force_unit, release_unit;
   logic [2:0] need_count;

   logic [3:0] o_grant [2];
   logic [3:0] o_ready [2];
   logic [3:0] o_rot   [2];
   logic [3:0] o_rem   [2];
   logic       o_pr    [2];
   logic       o_eu    [2];
   logic       o_er    [2];
   logic       o_ee    [2];

   rrsel_pool #(.W(4), .IS_GROUP(1'b0), .UNIT_COUNT(3), .ID_MASK(17'd0)) u0 (
      .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .force_en(force_en),
      .force_unit(force_unit), .release_en(release_en), .release_unit(release_unit),
      .reserve_set(reserve_set), .reserve_clr(reserve_clr), .need_count(need_count),
      .grant_unit(o_grant[0]), .pool_ready(o_pr[0]), .ready_mask(o_ready[0]),
      .rot_mask(o_rot[0]), .removed_mask(o_rem[0]), .err_use(o_eu[0]),
      .err_release(o_er[0]), .err_empty(o_ee[0]));

   rrsel_pool #(.W(4), .IS_GROUP(1'b1), .UNIT_COUNT(1), .ID_MASK(17'b10101)) u1 (
      .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .force_en(force_en),
      .force_unit(force_unit), .release_en(release_en), .release_unit(release_unit),
      .reserve_set(reserve_set), .reserve_clr(reserve_clr), .need_count(need_count),
      .grant_unit(o_grant[1]), .pool_ready(o_pr[1]), .ready_mask(o_ready[1]),
      .rot_mask(o_rot[1]), .removed_mask(o_rem[1]), .err_use(o_eu[1]),
      .err_release(o_er[1]), .err_empty(o_ee[1]));

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // reference state
   int member [2] = '{7, 5};
   int m_rot [2];
   int m_rem [2];
   int m_rdy [2];
   bit m_res [2];

   task automatic chk(input string tag, input int k, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s inst%0d actual=%0h expected=%0h t=%0t", tag, k, act, exp, $time);
      end
   endtask

   function automatic int top_of(input int v);
      int r = 0;
      for (int i = 0; i < 4; i++) if (v[i]) r = 1 << i;
      return r;
   endfunction

   function automatic int count_of(input int v);
      int n = 0;
      for (int i = 0; i < 4; i++) if (v[i]) n++;
      return n;
   endfunction

   task automatic model_reset();
      for (int k = 0; k < 2; k++) begin
         m_rot[k] = member[k]; m_rem[k] = 0; m_rdy[k] = member[k]; m_res[k] = 0;
      end
   endtask

   // compare at negedge, then advance reference to the next edge
   task automatic compare_and_step();
      for (int k = 0; k < 2; k++) begin
         int g, eu, er, ee, pr, use_ok, rel_ok, rot_a, rem_a;
         chk("R4 rot_mask", k, int'(o_rot[k]), m_rot[k]);
         chk("R5 removed_mask", k, int'(o_rem[k]), m_rem[k]);
         chk("R6 ready_mask", k, int'(o_ready[k]), m_rdy[k]);
         g = 0;
         if (sel_req) g = force_en ? int'(force_unit) : top_of(m_rot[k]);
         ee = (sel_req && !force_en && m_rot[k] == 0) ? 1 : 0;
         eu = ((g & ~m_rdy[k] & 15) != 0) ? 1 : 0;
         er = (release_en && ((int'(release_unit) & m_rdy[k]) != 0)) ? 1 : 0;
         pr = (!m_res[k] && count_of(m_rdy[k]) >= int'(need_count)) ? 1 : 0;
         chk("R3 grant_unit", k, int'(o_grant[k]), g);
         chk("R6 err_use", k, int'(o_eu[k]), eu);
         chk("R7 err_release", k, int'(o_er[k]), er);
         chk("R8 pool_ready", k, int'(o_pr[k]), pr);
         chk("R9 err_empty", k, int'(o_ee[k]), ee);
         use_ok = eu ? 0 : g;
         rel_ok = (release_en && !er) ? int'(release_unit) : 0;
         rot_a = m_rot[k]; rem_a = m_rem[k];
         if (sel_req) begin
            if (force_en && ((m_rot[k] & int'(force_unit)) == 0)) rem_a = m_rem[k] | int'(force_unit);
            else rot_a = m_rot[k] & ~g & 15;
         end
         if (sel_req && rot_a == 0) begin
            m_rot[k] = member[k] & ~rem_a & 15; m_rem[k] = 0;
         end else begin
            m_rot[k] = rot_a; m_rem[k] = rem_a;
         end
         m_rdy[k] = (m_rdy[k] | rel_ok) & ~use_ok & 15;
         if (reserve_set) m_res[k] = 1;
         else if (reserve_clr) m_res[k] = 0;
      end
   endtask

   task automatic cyc(input bit s, input bit f, input logic [3:0] fu, input bit re,
                      input logic [3:0] ru, input bit rs, input bit rc, input int nd);
      sel_req = s; force_en = f; force_unit = fu; release_en = re; release_unit = ru;
      reserve_set = rs; reserve_clr = rc; need_count = 3'(nd);
      @(negedge clk);
      compare_and_step();
      @(posedge clk); #1;
   endtask

   initial begin
      sel_req = 0; force_en = 0; force_unit = 0; release_en = 0; release_unit = 0;
      reserve_set = 0; reserve_clr = 0; need_count = 0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1, R2: reset state shows derived member masks
      chk("R1 member rot", 0, int'(o_rot[0]), 7);
      chk("R1 member rot", 1, int'(o_rot[1]), 5);
      chk("R2 reset ready", 0, int'(o_ready[0]), 7);
      chk("R2 reset removed", 1, int'(o_rem[1]), 0);
      chk("R2 reset not reserved", 0, int'(o_pr[0]), 1);
      @(posedge clk); #1 rst_n = 1'b1;
      // R3/R4: full round, then reload
      cyc(1, 0, 0, 0, 0, 0, 0, 1);
      cyc(1, 0, 0, 0, 0, 0, 0, 1);
      cyc(1, 0, 0, 0, 0, 0, 0, 1);
      // R8: ready count versus need, then reservation priority
      cyc(0, 0, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 4'b0100, 0, 0, 1);
      cyc(0, 0, 0, 1, 4'b0001, 1, 1, 1);
      cyc(0, 0, 0, 0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 0, 0, 1, 2);
      // R7: release of a ready unit
      cyc(0, 0, 0, 1, 4'b0001, 0, 0, 2);
      // R5: force a unit still in rotation, then one already passed
      cyc(1, 1, 4'b0001, 0, 0, 0, 0, 1);
      cyc(1, 0, 0, 1, 4'b0010, 0, 0, 1);
      cyc(1, 1, 4'b0100, 1, 4'b0001, 0, 0, 1);
      cyc(1, 0, 0, 1, 4'b0100, 0, 0, 1);
      cyc(1, 0, 0, 0, 0, 0, 0, 1);
      cyc(1, 0, 0, 0, 0, 0, 0, 1);
      // R6: granting a unit not ready
      cyc(1, 1, 4'b1000, 0, 0, 0, 0, 1);
      // mixed pseudo-random traffic
      for (int n = 0; n < 600; n++) begin
         int a = $urandom;
         cyc(a[0], a[1] & a[2], 4'(1 << a[5:4]), a[6], 4'(1 << a[9:8]),
             a[12] & a[13] & a[14], a[15], int'(a[18:16] % 5));
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule